// File: doc/BRIEF.md
# Operand Specifier Length Decoder

This block walks the operand specifiers of one already-fetched variable-length instruction and finds how many bytes each specifier occupies, along with its addressing mode and register number. The caller hands over a byte window (byte 0 is the opcode, the specifiers follow in order), the number of operands, and a data-size code for each operand. The block returns the per-specifier mode, register and length, the total instruction length and an illegal-encoding flag.

Work is sequential: after a request is accepted, one specifier is decoded per clock cycle, advancing a byte cursor by the length just found. Both edges are valid/ready. A request is taken only when `req_valid` and `req_ready` are both high on a rising edge. `req_ready` is high only while the block is idle. A finished result stays on the outputs, unchanged, with `res_valid` high until `res_ready` is seen high on a rising edge. No new request is taken while a result is waiting, so a stalled consumer stalls the producer.

Top module: `spec_len_decoder`

## Requirements
- R1: Each specifier's first byte is split into a mode (bits 7:4) and a register number (bits 3:0). These appear in that operand's slot of `res_mode` and `res_reg`. Slot i occupies bits [4i+3:4i].
- R2: Modes 0, 1, 2 and 3 are short literals. Each takes exactly 1 byte.
- R3: Mode 5 (register), 6 (register deferred), 7 (autodecrement), and modes 8 and 9 (autoincrement and autoincrement deferred) with a register other than 15 each take 1 byte.
- R4: Displacement modes take 1 byte plus the displacement. Modes A and B add 1 byte, modes C and D add 2 bytes, and modes E and F add 4 bytes.
- R5: Mode 8 with register 15 is an immediate. Its length is 1 plus the operand's data size. The 3-bit size code per operand (bits [3i+2:3i] of `req_sizes`) gives the size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes, and any code of 4 or more is 16 bytes.
- R6: Mode 9 with register 15 is an absolute address and takes 5 bytes.
- R7: Mode 4 is indexed. Its length is 1 plus the length of the base specifier in the following byte, using the same operand's size code. It raises `res_illegal` when the base mode is 0 to 3, 4 or 5 (literal, nested index, or register).
- R8: `res_total_len` is 1 plus the sum of all specifier lengths. Slots beyond the operand count report mode, register and length 0, so an operand count of 0 yields a total of 1.
- R9: `req_ready` is high only when idle. With N operands, `res_valid` rises N clock edges after the accepting edge; with N = 0 it rises on the accepting edge itself.
- R10: While `res_valid` is high and `res_ready` is low, every result output holds its value. A rising edge with `res_ready` high clears `res_valid` and returns the block to idle.
- R11: An operand count above 6 is treated as 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_bytes | input | 256 | Byte window; byte k at bits [8k+7:8k]; byte 0 is the opcode |
| req_count | input | 3 | Number of operand specifiers |
| req_sizes | input | 18 | Per-operand 3-bit data-size code |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_mode | output | 24 | Per-slot 4-bit mode |
| res_reg | output | 24 | Per-slot 4-bit register number |
| res_len | output | 30 | Per-slot 5-bit specifier length |
| res_total_len | output | 7 | Total instruction length in bytes |
| res_illegal | output | 1 | An indexed specifier had an illegal base |

## Verification
The checker watches the handshake on every cycle. It confirms that request and result are never both offered, that an accepted request drops `req_ready`, and that a stalled result holds its valid, lengths, total and flag. It also checks that the total is never below 1, that no slot length exceeds the largest legal specifier, and that a taken result returns the block to idle. The actual length of each mode, the register-15 reinterpretations, the size-dependent immediates, the indexed base rules, the count clamp and the exact latency need known byte patterns. Only the bench's directed scenarios show those.

// File: rtl/spec_len_pkg.sv
package spec_len_pkg;

  localparam logic [3:0] MODE_INDEX   = 4'h4;
  localparam logic [3:0] MODE_AINC    = 4'h8;
  localparam logic [3:0] MODE_AINCDEF = 4'h9;
  localparam logic [3:0] REG_PC       = 4'hF;
  localparam int unsigned SPEC_LEN_W  = 5;
  localparam int unsigned SPEC_LEN_MAX = 18;

  // Data size in bytes from a 3-bit log2 code; codes of 4 and above saturate at 16.
  function automatic logic [SPEC_LEN_W-1:0] size_bytes(input logic [2:0] code);
    logic [SPEC_LEN_W-1:0] r;
    case (code)
      3'd0:    r = 5'd1;
      3'd1:    r = 5'd2;
      3'd2:    r = 5'd4;
      3'd3:    r = 5'd8;
      default: r = 5'd16;
    endcase
    return r;
  endfunction

  // Length of a specifier that is not itself an index prefix.
  function automatic logic [SPEC_LEN_W-1:0] plain_len(input logic [7:0] spec,
                                                      input logic [2:0] code);
    logic [SPEC_LEN_W-1:0] r;
    case (spec[7:4])
      4'h8:    r = (spec[3:0] == REG_PC) ? 5'd1 + size_bytes(code) : 5'd1;
      4'h9:    r = (spec[3:0] == REG_PC) ? 5'd5 : 5'd1;
      4'hA, 4'hB: r = 5'd2;
      4'hC, 4'hD: r = 5'd3;
      4'hE, 4'hF: r = 5'd5;
      default: r = 5'd1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/spec_byte_pick.sv
module spec_byte_pick #(
  parameter int unsigned WIN_BYTES = 32,
  parameter int unsigned POS_W     = 7
) (
  input  logic [WIN_BYTES*8-1:0] window,
  input  logic [POS_W-1:0]       pos,
  output logic [7:0]             lead_byte,
  output logic [7:0]             next_byte
);
  logic [POS_W-1:0] pos_nx;
  assign pos_nx = pos + POS_W'(1);

  // Bytes past the end of the window read as zero.
  always_comb begin
    lead_byte = 8'h00;
    next_byte = 8'h00;
    for (int k = 0; k < WIN_BYTES; k++) begin
      if (pos == POS_W'(k))    lead_byte = window[k*8 +: 8];
      if (pos_nx == POS_W'(k)) next_byte = window[k*8 +: 8];
    end
  end
endmodule

// File: rtl/spec_classify.sv
module spec_classify
  import spec_len_pkg::*;
(
  input  logic [7:0]            lead_byte,
  input  logic [7:0]            next_byte,
  input  logic [2:0]            size_code,
  output logic [3:0]            mode,
  output logic [3:0]            regnum,
  output logic [SPEC_LEN_W-1:0] len,
  output logic                  bad_base
);
  logic [3:0] base_mode;

  assign mode      = lead_byte[7:4];
  assign regnum    = lead_byte[3:0];
  assign base_mode = next_byte[7:4];

  always_comb begin
    if (mode == MODE_INDEX) begin
      len      = 5'd1 + plain_len(next_byte, size_code);
      // literal (0-3), nested index (4) and register (5) cannot be indexed
      bad_base = (base_mode <= 4'h5);
    end else begin
      len      = plain_len(lead_byte, size_code);
      bad_base = 1'b0;
    end
  end
endmodule

// File: rtl/spec_len_decoder.sv
module spec_len_decoder
  import spec_len_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 32,
  parameter int unsigned MAX_OPS   = 6,
  parameter int unsigned SZ_W      = 3,
  localparam int unsigned CNT_W    = $clog2(MAX_OPS + 1),
  localparam int unsigned TOT_W    = $clog2(1 + MAX_OPS * SPEC_LEN_MAX + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [WIN_BYTES*8-1:0]         req_bytes,
  input  logic [CNT_W-1:0]               req_count,
  input  logic [MAX_OPS*SZ_W-1:0]        req_sizes,
  output logic                           res_valid,
  input  logic                           res_ready,
  output logic [MAX_OPS*4-1:0]           res_mode,
  output logic [MAX_OPS*4-1:0]           res_reg,
  output logic [MAX_OPS*SPEC_LEN_W-1:0]  res_len,
  output logic [TOT_W-1:0]               res_total_len,
  output logic                           res_illegal
);
  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_HOLD} walk_state_t;

  walk_state_t              state_q;
  logic [WIN_BYTES*8-1:0]   win_q;
  logic [MAX_OPS*SZ_W-1:0]  sizes_q;
  logic [CNT_W-1:0]         cnt_q;
  logic [CNT_W-1:0]         idx_q;
  logic [TOT_W-1:0]         pos_q;
  logic                     bad_q;

  logic [CNT_W-1:0]         cnt_clamped;
  logic                     take_req;
  logic                     take_res;
  logic [7:0]               lead_b, next_b;
  logic [2:0]               cur_size;
  logic [3:0]               cur_mode, cur_reg;
  logic [SPEC_LEN_W-1:0]    cur_len;
  logic                     cur_bad;

  assign cnt_clamped = (req_count > CNT_W'(MAX_OPS)) ? CNT_W'(MAX_OPS) : req_count;
  assign take_req    = req_valid && req_ready;
  assign take_res    = res_valid && res_ready;
  assign req_ready   = (state_q == ST_IDLE);
  assign res_valid   = (state_q == ST_HOLD);
  assign res_total_len = pos_q;
  assign res_illegal   = bad_q;

  always_comb begin
    cur_size = 3'd0;
    for (int k = 0; k < MAX_OPS; k++)
      if (idx_q == CNT_W'(k)) cur_size = sizes_q[k*SZ_W +: 3];
  end

  spec_byte_pick #(.WIN_BYTES(WIN_BYTES), .POS_W(TOT_W)) u_pick (
    .window    (win_q),
    .pos       (pos_q),
    .lead_byte (lead_b),
    .next_byte (next_b)
  );

  spec_classify u_class (
    .lead_byte (lead_b),
    .next_byte (next_b),
    .size_code (cur_size),
    .mode      (cur_mode),
    .regnum    (cur_reg),
    .len       (cur_len),
    .bad_base  (cur_bad)
  );

  // Walk control: one specifier per cycle, cursor starts past the opcode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
      sizes_q <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      pos_q   <= '0;
      bad_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (take_req) begin
          win_q   <= req_bytes;
          sizes_q <= req_sizes;
          cnt_q   <= cnt_clamped;
          idx_q   <= '0;
          pos_q   <= TOT_W'(1);
          bad_q   <= 1'b0;
          state_q <= (cnt_clamped == '0) ? ST_HOLD : ST_WALK;
        end
        ST_WALK: begin
          pos_q <= pos_q + TOT_W'(cur_len);
          bad_q <= bad_q | cur_bad;
          idx_q <= idx_q + CNT_W'(1);
          if (idx_q == cnt_q - CNT_W'(1)) state_q <= ST_HOLD;
        end
        ST_HOLD: if (take_res) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Per-operand result slots.
  for (genvar s = 0; s < MAX_OPS; s++) begin : g_slot
    logic [3:0]            mode_q, reg_q;
    logic [SPEC_LEN_W-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q <= '0;
        reg_q  <= '0;
        len_q  <= '0;
      end else if (state_q == ST_IDLE && take_req) begin
        mode_q <= '0;
        reg_q  <= '0;
        len_q  <= '0;
      end else if (state_q == ST_WALK && idx_q == CNT_W'(s)) begin
        mode_q <= cur_mode;
        reg_q  <= cur_reg;
        len_q  <= cur_len;
      end
    end

    assign res_mode[s*4 +: 4]                  = mode_q;
    assign res_reg[s*4 +: 4]                   = reg_q;
    assign res_len[s*SPEC_LEN_W +: SPEC_LEN_W] = len_q;
  end
endmodule

// File: rtl/spec_len_checker.sv
module spec_len_checker
  import spec_len_pkg::*;
#(
  parameter int unsigned MAX_OPS = 6,
  parameter int unsigned TOT_W   = 7
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_ready,
  input logic                          res_valid,
  input logic                          res_ready,
  input logic [MAX_OPS*SPEC_LEN_W-1:0] res_len,
  input logic [TOT_W-1:0]              res_total_len,
  input logic                          res_illegal
);
  a_r9_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r10_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid);

  a_r10_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> ($stable(res_total_len) && $stable(res_illegal) && $stable(res_len)));

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (!res_valid && req_ready));

  a_r8_total_floor: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_total_len >= TOT_W'(1)));

  for (genvar s = 0; s < MAX_OPS; s++) begin : g_cap
    a_r7_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_len[s*SPEC_LEN_W +: SPEC_LEN_W] <= SPEC_LEN_W'(SPEC_LEN_MAX)));
  end
endmodule

bind spec_len_decoder spec_len_checker #(.MAX_OPS(MAX_OPS), .TOT_W(TOT_W)) u_spec_len_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_len       (res_len),
  .res_total_len (res_total_len),
  .res_illegal   (res_illegal)
);

// File: tb/test_spec_len_decoder.sv
module test_spec_len_decoder;
  localparam int WB = 32;
  localparam int NO = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [WB*8-1:0] req_bytes = '0;
  logic [2:0]      req_count = '0;
  logic [NO*3-1:0] req_sizes = '0;
  logic            res_valid;
  logic            res_ready = 1'b0;
  logic [NO*4-1:0] res_mode, res_reg;
  logic [NO*5-1:0] res_len;
  logic [6:0]      res_total_len;
  logic            res_illegal;

  int n_checks = 0;
  int n_fail   = 0;
  int latency  = 0;
  logic [7:0] win [WB];
  logic [2:0] sz  [NO];

  always #10 clk = ~clk;

  spec_len_decoder i_spec_len_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bytes(req_bytes), .req_count(req_count), .req_sizes(req_sizes),
    .res_valid(res_valid), .res_ready(res_ready), .res_mode(res_mode),
    .res_reg(res_reg), .res_len(res_len), .res_total_len(res_total_len),
    .res_illegal(res_illegal)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_req();
    for (int k = 0; k < WB; k++) win[k] = 8'h00;
    for (int k = 0; k < NO; k++) sz[k] = 3'd2;
  endtask

  function automatic int slot_len(input int s);
    return int'(res_len[s*5 +: 5]);
  endfunction

  // Send one request and wait (consumer stalled) until a result is shown.
  task automatic launch(input int n);
    @(negedge clk);
    for (int k = 0; k < WB; k++) req_bytes[k*8 +: 8] = win[k];
    for (int k = 0; k < NO; k++) req_sizes[k*3 +: 3] = sz[k];
    req_count = 3'(n);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    latency = 0;
    while (!res_valid) begin
      @(negedge clk);
      latency++;
    end
  endtask

  task automatic release_res();
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 reset req_ready", int'(req_ready), 1);
    chk("R9 reset res_valid", int'(res_valid), 0);
  endtask

  task automatic t_worked_example();
    clear_req();
    win[0] = 8'hC1; win[1] = 8'h51; win[2] = 8'hC2; win[3] = 8'hE1; win[4] = 8'h02;
    win[5] = 8'h8F; sz[2] = 3'd2;
    launch(3);
    chk("R8 example total", int'(res_total_len), 10);
    chk("R1 mode slot1", int'(res_mode[7:4]), 12);
    chk("R1 reg slot1", int'(res_reg[7:4]), 2);
    chk("R3 register len", slot_len(0), 1);
    chk("R4 word disp len", slot_len(1), 3);
    chk("R5 long immediate len", slot_len(2), 5);
    chk("R7 no illegal", int'(res_illegal), 0);
    chk("R9 latency 3", latency, 3);
    release_res();
    chk("R10 back to idle", int'(req_ready), 1);
  endtask

  task automatic t_one_byte_modes();
    clear_req();
    win[1] = 8'h05; win[2] = 8'h3F; win[3] = 8'h63; win[4] = 8'h74; win[5] = 8'h92;
    launch(5);
    chk("R2 literal mode0", slot_len(0), 1);
    chk("R2 literal mode3", slot_len(1), 1);
    chk("R3 deferred", slot_len(2), 1);
    chk("R3 autodec", slot_len(3), 1);
    chk("R3 autoinc deferred non-PC", slot_len(4), 1);
    chk("R8 total one-byte", int'(res_total_len), 6);
    release_res();
  endtask

  task automatic t_displacements();
    clear_req();
    win[1] = 8'hA3; win[3] = 8'hB3; win[5] = 8'hD1; win[8] = 8'hE2; win[13] = 8'hF1;
    launch(5);
    chk("R4 byte disp", slot_len(0), 2);
    chk("R4 byte disp deferred", slot_len(1), 2);
    chk("R4 word disp deferred", slot_len(2), 3);
    chk("R4 long disp", slot_len(3), 5);
    chk("R4 long disp deferred", slot_len(4), 5);
    chk("R8 total disp", int'(res_total_len), 18);
    release_res();
  endtask

  task automatic t_pc_forms();
    clear_req();
    win[1] = 8'h9F; win[6] = 8'h8F; win[8] = 8'h8F; win[11] = 8'h8F; win[20] = 8'h8F;
    sz[1] = 3'd0; sz[2] = 3'd1; sz[3] = 3'd3; sz[4] = 3'd4;
    launch(5);
    chk("R6 absolute", slot_len(0), 5);
    chk("R5 immediate byte", slot_len(1), 2);
    chk("R5 immediate half", slot_len(2), 3);
    chk("R5 immediate quad", slot_len(3), 9);
    chk("R5 immediate octa", slot_len(4), 17);
    chk("R8 total pc forms", int'(res_total_len), 37);
    release_res();
  endtask

  task automatic t_indexed_ok();
    clear_req();
    win[1] = 8'h45; win[2] = 8'h62; win[3] = 8'h43; win[4] = 8'hC4;
    win[7] = 8'h41; win[8] = 8'h8F; sz[2] = 3'd2;
    launch(3);
    chk("R7 index deferred base", slot_len(0), 2);
    chk("R7 index word disp base", slot_len(1), 4);
    chk("R7 index immediate base", slot_len(2), 6);
    chk("R1 index mode", int'(res_mode[3:0]), 4);
    chk("R1 index reg", int'(res_reg[3:0]), 5);
    chk("R7 legal bases", int'(res_illegal), 0);
    chk("R8 total indexed", int'(res_total_len), 13);
    release_res();
  endtask

  task automatic t_indexed_bad(input logic [7:0] base, input string tag);
    clear_req();
    win[1] = 8'h41; win[2] = base;
    launch(1);
    chk(tag, int'(res_illegal), 1);
    chk("R7 bad base len", slot_len(0), 2);
    release_res();
  endtask

  task automatic t_zero_ops();
    clear_req();
    launch(0);
    chk("R8 zero-op total", int'(res_total_len), 1);
    chk("R8 unused slot0 len", slot_len(0), 0);
    chk("R8 unused slot0 mode", int'(res_mode[3:0]), 0);
    chk("R9 zero-op latency", latency, 0);
    release_res();
  endtask

  task automatic t_clamp();
    clear_req();
    for (int k = 1; k <= 7; k++) win[k] = 8'h50;
    launch(7);
    chk("R11 clamped total", int'(res_total_len), 7);
    chk("R11 clamped latency", latency, 6);
    release_res();
  endtask

  task automatic t_backpressure();
    logic [6:0] first_total;
    clear_req();
    win[1] = 8'hE5;
    launch(1);
    first_total = res_total_len;
    for (int k = 0; k < 5; k++) @(negedge clk);
    chk("R10 valid held", int'(res_valid), 1);
    chk("R10 total held", int'(res_total_len), int'(first_total));
    chk("R9 no ready while held", int'(req_ready), 0);
    chk("R4 held len", slot_len(0), 5);
    release_res();
    chk("R10 valid cleared", int'(res_valid), 0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_worked_example();
    t_zero_ops();
    t_one_byte_modes();
    t_displacements();
    t_pc_forms();
    t_indexed_ok();
    t_indexed_bad(8'h52, "R7 register base illegal");
    t_indexed_bad(8'h42, "R7 nested index illegal");
    t_indexed_bad(8'h10, "R7 literal base illegal");
    t_clamp();
    t_backpressure();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule